// File: doc/BRIEF.md
# Speaker and Timer-Gate Control Port

This block is a single byte-wide I/O register that a host reaches through a simple strobed read/write bus. Writing it drives two control lines: the gate input of an external interval-timer channel and an enable for the speaker data path. The timer channel itself, the audio path and any bus bridge are separate blocks. This block only holds the two control bits and reports status.

A read returns more than the stored bits. It also carries the live output level of the timer channel, which is brought in through a two-flop synchroniser. It further carries a status bit that inverts on every read of the port. Polling software uses that bit the way it would use a memory-refresh indicator, to see that something is changing.

The port answers one byte address only, 0x61 by default. Accesses to any other address leave every output and all internal state untouched. Read data is registered. It appears in the cycle after the read strobe and holds until the next read of the port.

Top module: `spkr_gate_port`

## Requirements
- R1: While reset is active and after its release, the gate output, the speaker-enable output, the read data and the read-toggle bit are all zero.
- R2: A write strobe whose address equals the port address (0x61 by default) sets the gate output to data bit 0 and the speaker-enable output to data bit 1, starting in the cycle after the strobe.
- R3: A read or write strobe to any address other than the port address changes neither output, leaves the read data as it was and does not advance the read-toggle bit.
- R4: On a read of the port, read-data bit 0 returns the current gate level and bit 1 returns the current speaker enable.
- R5: On a read of the port, read-data bit 5 returns the timer output level as sampled through two flip-flops. A level that is stable for two clock edges before the read strobe is reported.
- R6: On a read of the port, read-data bit 4 returns the read-toggle bit, which is zero for the first read after reset and inverts after every read of the port.
- R7: Writes to the port and cycles without a strobe do not change the read-toggle bit.
- R8: Read-data bits 2, 3, 6 and 7 are always zero.
- R9: Read data is updated only on the clock edge that samples a read strobe for the port. In every other cycle it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| tmr_level | input | 1 | Live output level of the timer channel (asynchronous) |
| tmr_gate | output | 1 | Gate drive for the timer channel |
| spk_enable | output | 1 | Speaker data enable |

## Verification
Every result has a fixed latency. A write strobe shows on the gate and speaker-enable outputs one edge later. A read strobe puts its data on `bus_rdata` one edge later. A change on the timer level reaches the read data only when the read strobe is sampled on the third edge after the change. The bench drives strobes on the falling edge and samples one falling edge after the capturing rising edge. For a level change, it lets two rising edges pass before it issues the read. Its reference model advances the toggle once per port read and never on writes, misses or idle cycles.

// File: rtl/spkr_gate_pkg.sv
// Package: shared constants for the speaker / timer-gate port.
// Assumes byte-wide data; the bit positions are the software-visible layout.
package spkr_gate_pkg;
    localparam int DATA_W        = 8;
    localparam int ADDR_W        = 16;
    localparam logic [ADDR_W-1:0] DEF_PORT_ADDR = 16'h0061;
    // Read/write field positions (software visible, fixed)
    localparam int POS_GATE      = 0;
    localparam int POS_SPK       = 1;
    localparam int POS_TOGGLE    = 4;
    localparam int POS_LEVEL     = 5;
endpackage

// File: rtl/spkr_port_decode.sv
// Module: spkr_port_decode
// Qualifies bus strobes with a single-address match.
// Assumes the strobes are one-cycle pulses; it adds no state.
module spkr_port_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    // Compare the full address against the single decoded port.
    always_comb begin
        match  = (addr == PORT_ADDR);
        wr_hit = wr && match;
        rd_hit = rd && match;
    end
endmodule

// File: rtl/spkr_level_sync.sv
// Module: spkr_level_sync
// Multi-stage synchroniser for the asynchronous timer level.
// Assumes STAGES >= 2; the output lags the input by STAGES rising edges.
module spkr_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage re-samples its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else        chain[gi] <= chain[gi-1];
            end

            // R5: every stage follows its predecessor one edge later.
            a_r5_stage_follows: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> chain[gi] == $past(chain[gi-1]));
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spkr_ctrl_regs.sv
// Module: spkr_ctrl_regs
// Holds the gate and speaker-enable bits and the read toggle, and builds
// the registered read word. Assumes qualified strobes from the decoder.
module spkr_ctrl_regs
    import spkr_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              level_sync,
    output logic              gate_q,
    output logic              spk_q,
    output logic [DATA_W-1:0] rdata
);
    logic              toggle_q;
    logic [DATA_W-1:0] rd_word;

    // Control bits: load from the write data on a port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            spk_q  <= 1'b0;
        end else if (wr_hit) begin
            gate_q <= wdata[POS_GATE];
            spk_q  <= wdata[POS_SPK];
        end
    end

    // Read toggle: inverts once per port read.
    always_ff @(posedge clk) begin
        if (!rst_n)      toggle_q <= 1'b0;
        else if (rd_hit) toggle_q <= ~toggle_q;
    end

    // Assemble the read word; unused bits stay zero.
    always_comb begin
        rd_word             = '0;
        rd_word[POS_GATE]   = gate_q;
        rd_word[POS_SPK]    = spk_q;
        rd_word[POS_TOGGLE] = toggle_q;
        rd_word[POS_LEVEL]  = level_sync;
    end

    // Read data register: capture on a port read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_hit) rdata <= rd_word;
    end

    // R2: a port write loads the gate and speaker bits one edge later.
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (gate_q == $past(wdata[POS_GATE])) && (spk_q == $past(wdata[POS_SPK])));
    // R3: without a port write the control bits hold.
    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(gate_q) && $stable(spk_q));
    // R6: every port read inverts the toggle.
    a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> toggle_q != $past(toggle_q));
    // R7: the toggle holds when no port read is made.
    a_r7_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(toggle_q));
    // R9: read data holds between port reads.
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(rdata));
    // R4: a port read returns the control bits that were current.
    a_r4_read_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (rdata[POS_GATE] == $past(gate_q)) && (rdata[POS_SPK] == $past(spk_q)));
endmodule

// File: rtl/spkr_gate_port.sv
// Module: spkr_gate_port (top)
// Byte-wide I/O port driving a timer gate and a speaker enable, reporting
// the synchronised timer level and a per-read toggle bit.
// Assumes one-cycle strobes; read data is valid the cycle after a read.
module spkr_gate_port
    import spkr_gate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR   = DEF_PORT_ADDR,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tmr_level,
    output logic              tmr_gate,
    output logic              spk_enable
);
    logic wr_hit;
    logic rd_hit;
    logic level_sync;

    // Address decode for the single port.
    spkr_port_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    // Synchroniser for the asynchronous timer output.
    spkr_level_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tmr_level),
        .q     (level_sync)
    );

    // Register file and read-word assembly.
    spkr_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .rd_hit     (rd_hit),
        .wdata      (bus_wdata),
        .level_sync (level_sync),
        .gate_q     (tmr_gate),
        .spk_q      (spk_enable),
        .rdata      (bus_rdata)
    );

    // R8: the unused read bits are always zero.
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bus_rdata[7:6] == 2'b00) && (bus_rdata[3:2] == 2'b00));
    // R5: a port read reports the synchronised timer level.
    a_r5_level_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> bus_rdata[POS_LEVEL] == $past(level_sync));
    // R1: during reset the outputs are driven to zero on the next edge.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (tmr_gate == 1'b0) && (spk_enable == 1'b0) && (bus_rdata == '0));
endmodule

// File: tb/test_spkr_gate_port.sv
// Bench: sweeps all write values, both timer levels and single-bit address
// misses, with a reference model of the gate, speaker and toggle bits.
module test_spkr_gate_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        tmr_level = 1'b0;
    logic        tmr_gate;
    logic        spk_enable;

    int n_tests = 0;
    int n_fail  = 0;
    bit m_gate = 0, m_spk = 0, m_tog = 0, m_lvl = 0;
    logic [7:0] m_rdata = '0;

    localparam logic [15:0] PORT = 16'h0061;

    always #2.5 clk = ~clk;

    spkr_gate_port i_spkr_gate_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tmr_level(tmr_level), .tmr_gate(tmr_gate), .spk_enable(spk_enable));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word();
        return {2'b00, m_lvl, m_tog, 2'b00, m_spk, m_gate};
    endfunction

    // One-cycle write; returns at the falling edge after the capturing edge.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        if (a == PORT) begin m_gate = d[0]; m_spk = d[1]; end
    endtask

    // One-cycle read; model updates the captured word and the toggle.
    task automatic bus_read(input logic [15:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        if (a == PORT) begin m_rdata = exp_word(); m_tog = ~m_tog; end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while in reset
        check("R1 gate in reset", {7'd0, tmr_gate}, 8'h00);
        check("R1 spk in reset", {7'd0, spk_enable}, 8'h00);
        check("R1 rdata in reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R6: first read after reset shows zero toggle and zero bits
        bus_read(PORT);
        check("R1 R6 first read", bus_rdata, 8'h00);

        // R2/R4/R6/R8: sweep all write values, read back each
        for (int v = 0; v < 256; v++) begin
            bus_write(PORT, 8'(v));
            check("R2 gate", {7'd0, tmr_gate}, {7'd0, m_gate});
            check("R2 spk", {7'd0, spk_enable}, {7'd0, m_spk});
            bus_read(PORT);
            check("R4 R6 R8 read word", bus_rdata, m_rdata);
        end

        // R9/R7: idle cycles and a write do not disturb data or toggle
        bus_write(PORT, 8'h01);
        repeat (5) @(negedge clk);
        check("R9 rdata hold", bus_rdata, m_rdata);
        bus_read(PORT);
        check("R7 toggle after write and idle", bus_rdata, m_rdata);

        // R5: timer level through the synchroniser, both levels
        for (int k = 0; k < 4; k++) begin
            tmr_level = k[0] ? 1'b0 : 1'b1;
            m_lvl = tmr_level;
            @(posedge clk); @(posedge clk); @(negedge clk);
            bus_read(PORT);
            check("R5 level bit", bus_rdata, m_rdata);
        end

        // R3: single-bit address misses, with writes that would flip the bits
        for (int b = 0; b < 16; b++) begin
            logic [15:0] miss;
            miss = PORT ^ (16'h1 << b);
            bus_write(miss, {6'd0, ~m_spk, ~m_gate});
            check("R3 gate on miss", {7'd0, tmr_gate}, {7'd0, m_gate});
            check("R3 spk on miss", {7'd0, spk_enable}, {7'd0, m_spk});
            bus_read(miss);
            check("R3 rdata on miss read", bus_rdata, m_rdata);
        end
        bus_read(PORT);
        check("R3 R7 toggle after misses", bus_rdata, m_rdata);

        // R6: run of back-to-back-spaced reads alternates the toggle
        for (int r = 0; r < 6; r++) begin
            bus_read(PORT);
            check("R6 toggle sequence", bus_rdata, m_rdata);
        end

        // R1: reset mid-run clears state again
        bus_write(PORT, 8'h03);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_gate = 0; m_spk = 0; m_tog = 0;
        check("R1 gate after reset", {7'd0, tmr_gate}, 8'h00);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        bus_read(PORT);
        check("R1 R6 read after reset", bus_rdata, m_rdata);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule